// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous request port and an asynchronous static RAM that has separate data-in and data-out pins. Each accepted request is a single access, either a read or a write. The controller turns it into active-low chip-select and write-enable strobes, a held address and write data, and every margin is a whole number of clock cycles set by a parameter. A request is taken with a valid/ready handshake. The port is ready only while the controller is idle. The address and write data are latched when the request is accepted, so the requester may change them on the next cycle.

For a write, the controller selects the RAM and drives the address for a setup period. It then pulls write enable low for the pulse width and releases it while the address, select and data stay put for a hold period. Write data only has to be on the pins for the last few cycles of the pulse. The pins carry zero before that, so the data path gets extra slack. For a read, write enable stays high while the RAM is selected with a steady address for the access time. The read data is then registered one cycle later and returned with a one-cycle response strobe. Between any two requests the RAM is deselected for at least one cycle.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `sram_cs_n` and `sram_we_n` are 1, `req_ready` is 1, `rsp_valid` is 0 and `sram_din` is 0.
- R2: `req_ready` is 1 only in the idle state. After an accepted write it is 0 for T_ASU+T_PW+T_HOLD cycles. After an accepted read it is 0 for T_ACC+1 cycles. It then returns to 1, and `sram_cs_n` is 1 in every cycle where `req_ready` is 1.
- R3: For a write, `sram_cs_n` is 0 and `sram_addr` carries the request address for T_ASU cycles before `sram_we_n` falls. `sram_we_n` is never 0 while `sram_cs_n` is 1.
- R4: For a write, `sram_we_n` is 0 for exactly T_PW consecutive cycles.
- R5: `sram_din` carries the write data during the last T_DSU cycles of the pulse and during the hold cycles. At all other times it is 0.
- R6: After `sram_we_n` rises, `sram_cs_n` stays 0 and `sram_addr` and `sram_din` stay unchanged for T_HOLD cycles. Then `sram_cs_n` returns to 1.
- R7: For a read, `sram_we_n` stays 1, and `sram_cs_n` is 0 with a constant `sram_addr` for T_ACC+1 cycles. `sram_dout` is sampled at the end of the last of these cycles.
- R8: `rsp_valid` is 1 for exactly one cycle, starting T_ACC+1 cycles after the accepting edge of a read, and it is never 1 for a write. `rsp_rdata` keeps the sampled value until the next read response.
- R9: A read returns the data of the most recent write to the same address.
- R10: Changes to `req_addr` and `req_wdata` after a request has been accepted have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request word address |
| req_wdata | input | DW | Request write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DW | Registered read data |
| sram_cs_n | output | 1 | RAM select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_addr | output | AW | RAM address |
| sram_din | output | DW | Data to the RAM data inputs |
| sram_dout | input | DW | Data from the RAM data outputs |

## Verification
The hardest case to reach from the ports is a margin that is one cycle too short. A read sampled one cycle early, a pulse one cycle short, or data released before the hold ends all still look like ordinary handshakes. The bench therefore attaches a behavioural RAM that drives zero until the address has been selected and steady for the access time, and that counts setup, pulse-width, data-setup and hold violations on every write. Nonzero patterns are written, including at both end addresses, and read back straight after one another. Any early sample or any violation then shows up both as wrong read data and in the final violation count. The request inputs are scrambled in the cycle after acceptance to expose any path that does not go through the latch.

// File: rtl/sram_ctl_pkg.sv
// Shared types for the asynchronous SRAM cycle controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sram_ctl_pkg;

    // Controller phases; writes walk SETUP/PULSE/HOLD, reads ACCESS/CAPTURE.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_PULSE   = 3'd2,
        ST_HOLD    = 3'd3,
        ST_ACCESS  = 3'd4,
        ST_CAPTURE = 3'd5
    } ctl_state_e;

    // Largest of four cycle counts, used to size the phase timer.
    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that measures how long the controller stays in one phase.
// A load sets the remaining cycles minus one; done is high in the last cycle.
// Assumes load is only raised on a phase change.
module sram_phase_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          done
);

    // Count down to zero and stop there until the next load.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // Without a load, a running count drops by exactly one per cycle (phase length, R4).
    p_timer_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sram_req_latch.sv
// Holds the accepted request fields for the whole access and registers read data.
// Assumes accept is a single-cycle pulse from the controller in its idle state.
module sram_req_latch #(
    parameter int AW = 10,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic [DW-1:0] sram_dout,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);

    // Latch address and write data on the accepting edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Register RAM output in the capture phase and raise a one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= sram_dout;
        end
    end

    // The response strobe never lasts longer than one cycle.
    p_rsp_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // Latched address is frozen whenever no request is taken.
    p_addr_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(addr_q));

endmodule

// File: rtl/sram_async_ctl.sv
// Cycle controller for an asynchronous separate-IO SRAM.
// Turns single-beat requests into timed select / write-enable / address / data
// waveforms. All margins are parameters in clock cycles.
// Assumes T_PW >= 1, 1 <= T_DSU <= T_PW, T_HOLD >= 1, T_ACC >= 1, T_ASU >= 0.
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW     = 10,
    parameter int DW     = 4,
    parameter int T_ASU  = 1,
    parameter int T_PW   = 2,
    parameter int T_DSU  = 1,
    parameter int T_HOLD = 1,
    parameter int T_ACC  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          sram_cs_n,
    output logic          sram_we_n,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_din,
    input  logic [DW-1:0] sram_dout
);

    localparam int MAXT = max4(T_ASU, T_PW, T_HOLD, T_ACC);
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] LD_ASU  = CW'((T_ASU > 0) ? T_ASU - 1 : 0);
    localparam logic [CW-1:0] LD_PW   = CW'(T_PW - 1);
    localparam logic [CW-1:0] LD_HOLD = CW'(T_HOLD - 1);
    localparam logic [CW-1:0] LD_ACC  = CW'(T_ACC - 1);
    localparam logic [CW-1:0] DSU_LIM = CW'(T_DSU);

    ctl_state_e    state_q, state_d;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic [CW-1:0] tmr_cnt;
    logic          tmr_done;
    logic          accept;
    logic          capture;
    logic          data_en;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    assign accept  = req_valid && (state_q == ST_IDLE);
    assign capture = (state_q == ST_CAPTURE);

    // Next phase and timer reload for each phase change.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    tmr_load = 1'b1;
                    if (!req_write) begin
                        state_d = ST_ACCESS;
                        tmr_val = LD_ACC;
                    end else if (T_ASU > 0) begin
                        state_d = ST_SETUP;
                        tmr_val = LD_ASU;
                    end else begin
                        state_d = ST_PULSE;
                        tmr_val = LD_PW;
                    end
                end
            end
            ST_SETUP: if (tmr_done) begin
                state_d  = ST_PULSE;
                tmr_load = 1'b1;
                tmr_val  = LD_PW;
            end
            ST_PULSE: if (tmr_done) begin
                state_d  = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = LD_HOLD;
            end
            ST_HOLD:    if (tmr_done) state_d = ST_IDLE;
            ST_ACCESS:  if (tmr_done) state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .done     (tmr_done)
    );

    sram_req_latch #(.AW(AW), .DW(DW)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .sram_dout (sram_dout),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // Data window: last T_DSU pulse cycles plus the hold phase.
    assign data_en = ((state_q == ST_PULSE) && (tmr_cnt < DSU_LIM)) || (state_q == ST_HOLD);

    // Pin decode straight from the phase flops.
    assign req_ready = (state_q == ST_IDLE);
    assign sram_cs_n = (state_q == ST_IDLE);
    assign sram_we_n = (state_q != ST_PULSE);
    assign sram_addr = addr_q;
    assign sram_din  = data_en ? wdata_q : '0;

    // Write enable only ever falls inside a selected access.
    p_we_inside_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_cs_n);

    // Selection precedes the falling write-enable edge when a setup is configured.
    if (T_ASU > 0) begin : g_setup_chk
        p_setup_before_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sram_we_n) |-> ($past(!sram_cs_n) && $stable(sram_addr)));
    end

    // Select and address survive the rising write-enable edge.
    p_hold_after_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_cs_n && $stable(sram_addr) && $stable(sram_din)));

    // Address never moves while the RAM stays selected.
    p_addr_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

    // An accepted request takes the port out of ready on the next cycle.
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // Data pins are quiet whenever the RAM is deselected.
    p_din_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_cs_n |-> (sram_din == '0));

endmodule

// File: tb/sram_async_ctl_bench.sv
`timescale 1ns/1ps
// Directed bench with a behavioural SRAM that counts timing violations.
module sram_async_ctl_bench;

    localparam int AW     = 10;
    localparam int DW     = 4;
    localparam int T_ASU  = 1;
    localparam int T_PW   = 2;
    localparam int T_DSU  = 1;
    localparam int T_HOLD = 1;
    localparam int T_ACC  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          sram_cs_n;
    logic          sram_we_n;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_din;
    logic [DW-1:0] sram_dout;

    int checks = 0;
    int errors = 0;
    int viol   = 0;

    always #2.5 clk = ~clk;

    sram_async_ctl #(
        .AW(AW), .DW(DW), .T_ASU(T_ASU), .T_PW(T_PW),
        .T_DSU(T_DSU), .T_HOLD(T_HOLD), .T_ACC(T_ACC)
    ) u_sram_async_ctl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_addr(sram_addr),
        .sram_din(sram_din), .sram_dout(sram_dout)
    );

    // Behavioural RAM: outputs zero until selected with a steady address for T_ACC cycles.
    logic [DW-1:0] mem [0:(1<<AW)-1];
    int            stab = 0;
    logic [AW-1:0] last_addr = '0;
    logic [DW-1:0] last_din = '0;
    logic          prev_we = 1'b1;
    int            dstab = 0, ds_low = 0, pw = 0, hold_left = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;

    initial begin
        for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    end

    assign sram_dout = (!sram_cs_n && sram_we_n && sram_addr == last_addr && stab >= T_ACC)
                       ? mem[sram_addr] : '0;

    // Track the cycle just before each edge and count margin violations.
    always @(posedge clk) begin
        if (!rst_n) begin
            stab <= 0; prev_we = 1'b1; pw = 0; hold_left = 0; dstab = 0;
        end else begin
            dstab = (sram_din == last_din) ? dstab + 1 : 1;
            if (!sram_we_n && prev_we) begin
                if (sram_cs_n || (T_ASU > 0 && (sram_addr != last_addr || stab < T_ASU))) viol++;
                pw = 0;
            end
            if (!sram_we_n) begin
                if (pw > 0 && (sram_addr != wr_addr || sram_cs_n)) viol++;
                pw++;
                wr_addr = sram_addr;
                wr_data = sram_din;
                ds_low  = dstab;
            end else if (!prev_we) begin
                if (pw < T_PW || ds_low < T_DSU) viol++;
                mem[wr_addr] <= wr_data;
                if (sram_cs_n || sram_addr != wr_addr || sram_din != wr_data) viol++;
                hold_left = T_HOLD - 1;
            end else if (hold_left > 0) begin
                if (sram_cs_n || sram_addr != wr_addr || sram_din != wr_data) viol++;
                hold_left--;
            end
            if (sram_cs_n)                    stab <= 0;
            else if (sram_addr == last_addr)  stab <= stab + 1;
            else                              stab <= 1;
            prev_we = sram_we_n;
        end
        last_addr <= sram_addr;
        last_din  <= sram_din;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // R1: reset state, during and just after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(sram_cs_n == 1'b1 && sram_we_n == 1'b1, "R1", "strobes in reset",
              {sram_cs_n, sram_we_n}, 2'b11);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "ready/rsp in reset",
              {req_ready, rsp_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(sram_cs_n && sram_we_n && req_ready && !rsp_valid && sram_din == '0,
              "R1", "state after reset", {sram_cs_n, sram_we_n, req_ready, rsp_valid}, 4'b1110);
    endtask

    // One write; every cycle of the waveform is compared (R2-R6, R10).
    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        check(req_ready == 1'b1, "R2", "ready before write", req_ready, 1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;   // R10: scrambled after accept
        for (int k = 0; k < T_ASU; k++) begin
            check(!sram_cs_n && sram_we_n && !req_ready, "R3", "setup strobes",
                  {sram_cs_n, sram_we_n, req_ready}, 3'b010);
            check(sram_addr == a, "R10", "setup address", sram_addr, a);
            check(sram_din == '0, "R5", "din before window", sram_din, 0);
            @(negedge clk);
        end
        for (int k = 0; k < T_PW; k++) begin
            check(!sram_cs_n && !sram_we_n && !req_ready, "R4", "pulse strobes",
                  {sram_cs_n, sram_we_n, req_ready}, 3'b000);
            check(sram_addr == a, "R3", "pulse address", sram_addr, a);
            check(sram_din == ((k >= T_PW - T_DSU) ? d : '0), "R5", "din in pulse",
                  sram_din, (k >= T_PW - T_DSU) ? d : 0);
            @(negedge clk);
        end
        for (int k = 0; k < T_HOLD; k++) begin
            check(!sram_cs_n && sram_we_n && !req_ready, "R6", "hold strobes",
                  {sram_cs_n, sram_we_n, req_ready}, 3'b010);
            check(sram_addr == a && sram_din == d, "R6", "hold addr/data",
                  {sram_addr, sram_din}, {a, d});
            @(negedge clk);
        end
        check(sram_cs_n && sram_we_n && req_ready && !rsp_valid, "R2", "idle after write",
              {sram_cs_n, sram_we_n, req_ready, rsp_valid}, 4'b1110);
        check(!rsp_valid, "R8", "no response for write", rsp_valid, 0);
    endtask

    // One read; strobes, response timing and data (R2, R7, R8, R9, R10).
    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        check(req_ready == 1'b1, "R2", "ready before read", req_ready, 1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a;
        for (int k = 0; k < T_ACC + 1; k++) begin
            check(!sram_cs_n && sram_we_n && !req_ready && !rsp_valid, "R7", "read strobes",
                  {sram_cs_n, sram_we_n, req_ready, rsp_valid}, 4'b0100);
            check(sram_addr == a, "R7", "read address", sram_addr, a);
            @(negedge clk);
        end
        check(rsp_valid && req_ready && sram_cs_n, "R8", "response strobe",
              {rsp_valid, req_ready, sram_cs_n}, 3'b111);
        check(rsp_rdata == exp, "R9", "read data", rsp_rdata, exp);
        @(negedge clk);
        check(!rsp_valid, "R8", "response one cycle", rsp_valid, 0);
        check(rsp_rdata == exp, "R8", "response data held", rsp_rdata, exp);
    endtask

    // Scenario: fill end and middle addresses, read all back (R9).
    task automatic sc_fill_readback();
        t_write(10'h000, 4'h5);
        t_write(10'h3FF, 4'hA);
        t_write(10'h155, 4'hC);
        t_write(10'h2AA, 4'h3);
        t_read(10'h3FF, 4'hA);
        t_read(10'h000, 4'h5);
        t_read(10'h2AA, 4'h3);
        t_read(10'h155, 4'hC);
    endtask

    // Scenario: overwrite one address, then read it straight after the write (R9).
    task automatic sc_overwrite();
        t_write(10'h0F0, 4'h9);
        t_write(10'h0F0, 4'h6);
        t_read(10'h0F0, 4'h6);
        t_write(10'h001, 4'hF);
        t_read(10'h001, 4'hF);
    endtask

    // Scenario: idle gap keeps the RAM deselected, then a read after it (R2).
    task automatic sc_idle_gap();
        for (int k = 0; k < 4; k++) begin
            check(sram_cs_n && req_ready && sram_din == '0, "R2", "idle gap",
                  {sram_cs_n, req_ready}, 2'b11);
            @(negedge clk);
        end
        t_read(10'h3FF, 4'hA);
    endtask

    initial begin
        t_reset();
        sc_fill_readback();
        sc_overwrite();
        sc_idle_gap();
        @(negedge clk);
        check(viol == 0, "R3", "model setup/pulse/hold violations", viol, 0);
        finish_run();
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog expired: actual 1 expected 0");
        finish_run();
    end

endmodule